// File: doc/BRIEF.md
# Migratory Coherence Home Directory Controller

This block is the home-side directory controller for a single cache line under a migratory coherence scheme, where at most one remote cache holds the line at a time. A fixed set of remote nodes sends messages to the home over lossless, in-order point-to-point channels. Each node can send a request for the line, an eviction writeback, or an invalidate acknowledgement that carries the line data. The home answers on a single outbound channel with a grant that carries the data, an invalidate (recall) aimed at the current owner, or a nack.

The controller has two stable states and one transient state. Free means no remote copy exists, and the home holds the data. Exclusive means one owner holds the line. Recall means an invalidate is outstanding and a new requester is waiting for the line. A request from another node while the line is Exclusive starts a recall. The recall ends when the owner sends data back, either as an acknowledgement or as an eviction writeback that crossed the invalidate in the channel. The data then goes straight to the waiting node.

Any request that arrives while a recall is outstanding is nacked rather than stored. This includes a request that crossed the home's own invalidate. Because of this the controller always has an answer, and a single outbound message slot is enough. When several nodes present messages in the same cycle, a round-robin arbiter picks one of them, and only one message is accepted per cycle.

Top module: `mig_home_dir`

## Requirements
- R1: After reset (synchronous, active low) the line is Free with data zero, no outbound message is valid, and no inbound message is accepted while reset is held.
- R2: In Free, a request (inbound type 0) from node i produces a grant (outbound type 0) to i carrying the home's line data, and node i becomes the owner in Exclusive.
- R3: In Exclusive, a request from a node other than the owner produces an invalidate (outbound type 1) to the current owner and enters Recall with that requester waiting.
- R4: In Recall, an eviction writeback (inbound type 1) or an invalidate acknowledgement (inbound type 2) from the owner produces a grant to the waiting node carrying that message's data; the waiting node becomes owner and the state returns to Exclusive.
- R5: In Exclusive, an eviction writeback from the owner returns the line to Free with no outbound message, and the written-back data is carried by the next grant from Free.
- R6: In Recall, a request from any node, including one that crossed the invalidate, is answered with a nack (outbound type 2) to that node and leaves the recall unchanged.
- R7: In Exclusive, a request from the current owner is answered with a nack to the owner and changes nothing.
- R8: Writebacks and acknowledgements from non-owners, any of them in Free, acknowledgements in Exclusive, and inbound type 3 are consumed with no outbound message and no state change.
- R9: Among nodes with a valid message, the one at or after the round-robin pointer (in increasing index order, wrapping) is accepted, and the pointer then moves to the node just after it; the pointer starts at node 0.
- R10: At most one inbound message is accepted per cycle, and only while the outbound slot is empty or being taken (out_ready high). An outbound message held with out_ready low stays valid and unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | NODES | Per-node inbound message valid |
| in_type | input | 2*NODES | Per-node inbound type, node k in bits [2k+1:2k]: 0 request, 1 eviction writeback, 2 invalidate acknowledgement, 3 ignored |
| in_data | input | NODES*DATA_W | Per-node inbound data, node k in bits [DATA_W*(k+1)-1:DATA_W*k] |
| in_ready | output | NODES | One-hot accept of the message the home consumes this cycle |
| out_valid | output | 1 | Outbound message valid |
| out_ready | input | 1 | Outbound channel takes the message |
| out_type | output | 2 | Outbound type: 0 grant, 1 invalidate, 2 nack |
| out_dest | output | $clog2(NODES) | Destination node of the outbound message |
| out_data | output | DATA_W | Line data for a grant, zero otherwise |

## Verification
The bench concentrates on four situations. The first is a writeback that crosses an invalidate; a design that waited only for the acknowledgement would hang in Recall. The second is a request that crosses the invalidate; a design that queued it or dropped it silently would either need unbounded storage or leave that node waiting forever. The third is a request from the current owner; a design that granted it would hand out a second copy. The fourth is data taken from the eviction into the next Free-state grant; a design that kept stale data would return the old value. Round-robin fairness under simultaneous requests, and the hold of a stalled outbound message, are checked as well: a fixed-priority arbiter would serve the same node again, and a slot that did not hold would lose or overwrite a nack.

// File: rtl/mig_dir_pkg.sv
// Shared encodings for the migratory home directory controller.
// Assumes 2-bit message type fields on both channels.
package mig_dir_pkg;

    // Inbound message kinds sent by remote nodes
    typedef enum logic [1:0] {
        RQ_GET    = 2'd0,
        RQ_EVICT  = 2'd1,
        RQ_INVACK = 2'd2,
        RQ_RSVD   = 2'd3
    } in_msg_e;

    // Outbound message kinds sent by the home
    typedef enum logic [1:0] {
        RS_GRANT = 2'd0,
        RS_INV   = 2'd1,
        RS_NACK  = 2'd2
    } out_msg_e;

    // Directory line state
    typedef enum logic [1:0] {
        ST_FREE   = 2'd0,
        ST_EXCL   = 2'd1,
        ST_RECALL = 2'd2
    } dir_state_e;

endpackage

// File: rtl/rr_arb.sv
// Round-robin picker over N request lines.
// It grants the first asserted line at or after the pointer, wrapping.
// The pointer moves just past the winner only when the caller says the
// grant was used (advance). Assumes N >= 2.
module rr_arb #(
    parameter int N = 4,
    localparam int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         advance,
    output logic [N-1:0] gnt_oh,
    output logic [W-1:0] gnt_idx,
    output logic         gnt_any
);

    logic [W-1:0] ptr;

    // Search from the pointer upward and take the first live request
    always_comb begin
        int cand;
        logic [W-1:0] cidx;
        gnt_oh  = '0;
        gnt_idx = '0;
        gnt_any = 1'b0;
        for (int k = 0; k < N; k++) begin
            cand = (int'(ptr) + k) % N;
            cidx = W'(cand);
            if (!gnt_any && req[cidx]) begin
                gnt_any       = 1'b1;
                gnt_idx       = cidx;
                gnt_oh[cidx]  = 1'b1;
            end
        end
    end

    // Move the pointer past a winner that was actually consumed
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (advance) begin
            ptr <= (gnt_idx == W'(N - 1)) ? '0 : gnt_idx + W'(1);
        end
    end

    // R9
    rr_ptr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req[ptr] |-> (gnt_any && gnt_idx == ptr));

endmodule

// File: rtl/dir_fsm.sv
// Directory state machine for one line: it tracks state, owner, waiting
// requester and the home copy of the data, and it holds the single
// outbound message slot. Assumes acc is raised only when the slot is
// free, and that src, msg and msg_data describe the accepted message.
module dir_fsm
    import mig_dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int DATA_W = 32,
    localparam int NODE_W = $clog2(NODES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic [NODE_W-1:0] src,
    input  in_msg_e           msg,
    input  logic [DATA_W-1:0] msg_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [1:0]        out_type,
    output logic [NODE_W-1:0] out_dest,
    output logic [DATA_W-1:0] out_data
);

    dir_state_e        state, nx_state;
    logic [NODE_W-1:0] owner, nx_owner;
    logic [NODE_W-1:0] pend, nx_pend;
    logic [DATA_W-1:0] line, nx_line;

    logic              emit;
    out_msg_e          e_type;
    logic [NODE_W-1:0] e_dest;
    logic [DATA_W-1:0] e_data;

    out_msg_e          o_type;

    // Decide the next line state and any reply for the accepted message
    always_comb begin
        nx_state = state;
        nx_owner = owner;
        nx_pend  = pend;
        nx_line  = line;
        emit     = 1'b0;
        e_type   = RS_NACK;
        e_dest   = src;
        e_data   = '0;
        if (acc) begin
            case (state)
                ST_FREE: begin
                    if (msg == RQ_GET) begin
                        emit     = 1'b1;
                        e_type   = RS_GRANT;
                        e_data   = line;
                        nx_owner = src;
                        nx_state = ST_EXCL;
                    end
                end
                ST_EXCL: begin
                    if (msg == RQ_GET) begin
                        emit = 1'b1;
                        if (src == owner) begin
                            e_type = RS_NACK;
                        end else begin
                            e_type   = RS_INV;
                            e_dest   = owner;
                            nx_pend  = src;
                            nx_state = ST_RECALL;
                        end
                    end else if (msg == RQ_EVICT && src == owner) begin
                        nx_line  = msg_data;
                        nx_state = ST_FREE;
                    end
                end
                ST_RECALL: begin
                    if (msg == RQ_GET) begin
                        emit   = 1'b1;
                        e_type = RS_NACK;
                    end else if ((msg == RQ_EVICT || msg == RQ_INVACK) && src == owner) begin
                        emit     = 1'b1;
                        e_type   = RS_GRANT;
                        e_dest   = pend;
                        e_data   = msg_data;
                        nx_line  = msg_data;
                        nx_owner = pend;
                        nx_state = ST_EXCL;
                    end
                end
                default: begin
                    nx_state = ST_FREE;
                end
            endcase
        end
    end

    // Register the line state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FREE;
            owner <= '0;
            pend  <= '0;
            line  <= '0;
        end else begin
            state <= nx_state;
            owner <= nx_owner;
            pend  <= nx_pend;
            line  <= nx_line;
        end
    end

    // Load the outbound slot with a new reply, or empty it when taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            o_type    <= RS_NACK;
            out_dest  <= '0;
            out_data  <= '0;
        end else if (emit) begin
            out_valid <= 1'b1;
            o_type    <= e_type;
            out_dest  <= e_dest;
            out_data  <= e_data;
        end else if (out_ready) begin
            out_valid <= 1'b0;
        end
    end

    assign out_type = o_type;

    // R2
    free_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && state == ST_FREE && msg == RQ_GET) |=>
            (out_valid && out_type == 2'd0 && out_dest == $past(src)
             && out_data == $past(line) && state == ST_EXCL));

    // R3
    recall_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && state == ST_EXCL && msg == RQ_GET && src != owner) |=>
            (out_valid && out_type == 2'd1 && out_dest == $past(owner)
             && state == ST_RECALL));

    // R4
    recall_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECALL) |-> (owner != pend));

    // R6
    recall_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && state == ST_RECALL && msg == RQ_GET) |=>
            (out_valid && out_type == 2'd2 && out_dest == $past(src)
             && state == ST_RECALL && $stable(pend)));

endmodule

// File: rtl/mig_home_dir.sv
// Top of the migratory home directory controller for one cache line.
// It splits the flat per-node inbound buses, picks one node per cycle
// with the round-robin arbiter, and hands the chosen message to the
// directory state machine, which owns the outbound slot.
// Assumes in-order lossless channels and NODES >= 2.
module mig_home_dir
    import mig_dir_pkg::*;
#(
    parameter int NODES  = 4,
    parameter int DATA_W = 32,
    localparam int NODE_W = $clog2(NODES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NODES-1:0]         in_valid,
    input  logic [2*NODES-1:0]       in_type,
    input  logic [NODES*DATA_W-1:0]  in_data,
    output logic [NODES-1:0]         in_ready,
    output logic                     out_valid,
    input  logic                     out_ready,
    output logic [1:0]               out_type,
    output logic [NODE_W-1:0]        out_dest,
    output logic [DATA_W-1:0]        out_data
);

    logic [NODES-1:0]  gnt_oh;
    logic [NODE_W-1:0] gnt_idx;
    logic              gnt_any;
    logic              slot_free;
    logic              accept;

    logic [1:0]        typ_arr [NODES];
    logic [DATA_W-1:0] dat_arr [NODES];

    // Split the flat inbound buses into per-node fields
    for (genvar g = 0; g < NODES; g++) begin : g_split
        assign typ_arr[g] = in_type[2*g +: 2];
        assign dat_arr[g] = in_data[DATA_W*g +: DATA_W];
    end

    // Accept one message only when the outbound slot can take a reply
    assign slot_free = !out_valid || out_ready;
    assign accept    = rst_n && slot_free && gnt_any;
    assign in_ready  = accept ? gnt_oh : '0;

    rr_arb #(.N(NODES)) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (in_valid),
        .advance (accept),
        .gnt_oh  (gnt_oh),
        .gnt_idx (gnt_idx),
        .gnt_any (gnt_any)
    );

    dir_fsm #(.NODES(NODES), .DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (accept),
        .src       (gnt_idx),
        .msg       (in_msg_e'(typ_arr[gnt_idx])),
        .msg_data  (dat_arr[gnt_idx]),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_type  (out_type),
        .out_dest  (out_dest),
        .out_data  (out_data)
    );

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
            (out_valid && $stable(out_type) && $stable(out_dest) && $stable(out_data)));

    // R10
    one_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(in_ready) && ((in_ready & ~in_valid) == '0));

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (in_ready == '0));

endmodule

// File: tb/sim_mig_home_dir.sv
`timescale 1ns/1ps
module sim_mig_home_dir;

    localparam int N  = 4;
    localparam int DW = 32;
    localparam int NW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]    v = '0;
    logic [2*N-1:0]  t = '0;
    logic [N*DW-1:0] d = '0;
    logic            ordy = 1'b1;
    logic [N-1:0]    in_ready;
    logic            out_valid;
    logic [1:0]      out_type;
    logic [NW-1:0]   out_dest;
    logic [DW-1:0]   out_data;

    always #4 clk = ~clk;

    mig_home_dir #(.NODES(N), .DATA_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(v), .in_type(t), .in_data(d),
        .in_ready(in_ready), .out_valid(out_valid), .out_ready(ordy),
        .out_type(out_type), .out_dest(out_dest), .out_data(out_data)
    );

    int nchk = 0;
    int nbad = 0;
    bit done = 0;

    // behavioural reference: 0 free, 1 exclusive, 2 recall
    int m_st = 0, m_own = 0, m_pend = 0, m_ptr = 0;
    logic [DW-1:0] m_line = '0;
    bit m_ov = 0;
    int m_ot = 0, m_od = 0;
    logic [DW-1:0] m_odat = '0;
    string m_tag = "R1";
    int m_acc_w = -1;

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int pick();
        for (int k = 0; k < N; k++) begin
            int j = (m_ptr + k) % N;
            if (v[j]) return j;
        end
        return -1;
    endfunction

    task automatic emit(int ty, int dst, logic [DW-1:0] dat);
        m_ov = 1; m_ot = ty; m_od = dst; m_odat = dat;
    endtask

    task automatic model_edge();
        int w, ty;
        bit fr;
        logic [DW-1:0] dat;
        m_acc_w = -1;
        if (!rst_n) begin
            m_st = 0; m_own = 0; m_pend = 0; m_ptr = 0; m_line = '0; m_ov = 0; m_tag = "R1";
            return;
        end
        w  = pick();
        fr = !m_ov || ordy;
        if (fr) m_ov = 0;
        if (fr && w >= 0) begin
            m_acc_w = w;
            m_ptr = (w + 1) % N;
            ty  = int'(t[w*2 +: 2]);
            dat = d[w*DW +: DW];
            m_tag = "R8";
            case (m_st)
                0: if (ty == 0) begin
                       emit(0, w, m_line); m_own = w; m_st = 1; m_tag = "R2";
                   end
                1: if (ty == 0) begin
                       if (w == m_own) begin emit(2, w, '0); m_tag = "R7"; end
                       else begin emit(1, m_own, '0); m_pend = w; m_st = 2; m_tag = "R3"; end
                   end else if (ty == 1 && w == m_own) begin
                       m_line = dat; m_st = 0; m_tag = "R5";
                   end
                default: if (ty == 0) begin
                       emit(2, w, '0); m_tag = "R6";
                   end else if ((ty == 1 || ty == 2) && w == m_own) begin
                       emit(0, m_pend, dat); m_line = dat; m_own = m_pend; m_st = 1; m_tag = "R4";
                   end
            endcase
        end else begin
            m_tag = "R10";
        end
    endtask

    // one clock: check accept before the edge, advance the model, check outputs after
    task automatic step();
        int w;
        logic [N-1:0] er;
        #1;
        w  = pick();
        er = (rst_n && (!m_ov || ordy) && w >= 0) ? (N'(1) << w) : '0;
        check(in_ready == er, !rst_n ? "R1" : "R9", "in_ready", in_ready, er);
        @(posedge clk);
        model_edge();
        #1;
        check(out_valid == m_ov, m_tag, "out_valid", out_valid, m_ov);
        if (m_ov) begin
            check(out_type == 2'(m_ot), m_tag, "out_type", out_type, m_ot);
            check(out_dest == NW'(m_od), m_tag, "out_dest", out_dest, m_od);
            if (m_ot == 0) check(out_data == m_odat, m_tag, "out_data", out_data, m_odat);
        end
        @(negedge clk);
    endtask

    task automatic send(int n, int ty, logic [DW-1:0] dat);
        v = '0;
        v[n] = 1'b1;
        t[n*2 +: 2] = 2'(ty);
        d[n*DW +: DW] = dat;
        step();
        v = '0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", nchk, nbad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        logic [N-1:0] seen;
        int held;
        @(negedge clk);
        // R1: requests during reset are not accepted and nothing is sent
        v = 4'b0001;
        repeat (3) step();
        check(out_valid == 1'b0, "R1", "out_valid in reset", out_valid, 0);
        v = '0;
        rst_n = 1'b1;
        step();

        send(1, 0, 32'h0);
        check(out_valid && out_type == 2'd0 && out_dest == 2'd1 && out_data == 32'h0,
              "R2", "grant from free after reset", out_dest, 1);
        send(2, 0, 32'h0);
        check(out_type == 2'd1 && out_dest == 2'd1, "R3", "invalidate to owner", out_dest, 1);
        send(3, 0, 32'h0);
        check(out_type == 2'd2 && out_dest == 2'd3, "R6", "nack during recall", out_dest, 3);
        send(0, 2, 32'h55);
        check(out_valid == 1'b0, "R8", "non-owner ack ignored", out_valid, 0);
        send(1, 2, 32'hA5A5_0001);
        check(out_type == 2'd0 && out_dest == 2'd2 && out_data == 32'hA5A5_0001,
              "R4", "ack hands line to waiter", out_data, 32'hA5A5_0001);
        send(2, 0, 32'h0);
        check(out_type == 2'd2 && out_dest == 2'd2, "R7", "owner request nacked", out_dest, 2);
        send(3, 1, 32'h77);
        check(out_valid == 1'b0, "R8", "non-owner writeback ignored", out_valid, 0);
        send(2, 1, 32'hBEEF_0002);
        check(out_valid == 1'b0, "R5", "eviction sends nothing", out_valid, 0);
        send(0, 0, 32'h0);
        check(out_type == 2'd0 && out_dest == 2'd0 && out_data == 32'hBEEF_0002,
              "R5", "evicted data in next grant", out_data, 32'hBEEF_0002);
        send(3, 0, 32'h0);
        check(out_type == 2'd1 && out_dest == 2'd0, "R3", "recall from node 0", out_dest, 0);

        // R9 / R10: all nodes request during recall, with one stall
        seen = '0;
        held = 0;
        ordy = 1'b1;
        v = '1;
        t = '0;
        for (int i = 0; i < N; i++) begin
            step();
            if (m_acc_w >= 0) v[m_acc_w] = 1'b0;
            seen[out_dest] = 1'b1;
            if (i == 0) begin
                held = int'(out_dest);
                ordy = 1'b0;
                step();
                step();
                check(out_valid && out_dest == NW'(held), "R10", "stalled nack held", out_dest, held);
                ordy = 1'b1;
            end
        end
        check(seen == '1, "R9", "every node served once", seen, 4'hF);
        v = '0;

        // R4: writeback that crossed the invalidate completes the recall
        send(0, 1, 32'hC0DE_0003);
        check(out_type == 2'd0 && out_dest == 2'd3 && out_data == 32'hC0DE_0003,
              "R4", "crossing writeback hands line", out_data, 32'hC0DE_0003);

        // mixed traffic against the reference
        for (int c = 0; c < 600; c++) begin
            v = N'($urandom);
            t = (2*N)'($urandom);
            for (int k = 0; k < N; k++) d[k*DW +: DW] = $urandom;
            ordy = ($urandom % 4) != 0;
            step();
        end
        v = '0;
        ordy = 1'b1;
        step();
        finish_run();
    end

endmodule